// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block holds the digital mode logic of a single-wire LIN transceiver. It takes an enable pin, a transmit-data pin and the digital output of the bus receiver comparator. It produces the request that pulls the bus dominant, the receive-data pin, the enable of a high-side inhibit pin that switches an external voltage regulator, and a regulator-on status.

Leaving reset, the controller passes through a one-cycle power-up state into standby, with the regulator running. Raising the enable pin moves it into normal mode from any state. There, transmit data drives the bus and receive data mirrors it. Dropping the enable pin in normal mode puts the node to sleep: the inhibit pin floats and the regulator turns off. A dominant bus level that outlasts a programmable filter time brings the node back to standby. A wake flag then holds receive data low until software selects normal mode again.

The filter time is WAKE_TICKS ticks of TICK_DIV clock cycles each. Every pin input passes through a two-flop synchronizer before the logic uses it.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While rst_n is low, and in standby after reset, rxd_o is 1, bus_dom_o is 0, inh_en_o is 1 and reg_on_o is 1.
- R2: A synchronized en_i of 1 selects normal mode from standby or sleep, with no bus wake-up needed.
- R3: In normal mode, txd_i low sets bus_dom_o to 1 (dominant request) and txd_i high sets it to 0.
- R4: In normal mode, rxd_o equals the synchronized bus_rx_i, where 0 means a dominant bus.
- R5: In normal mode, en_i low selects sleep: inh_en_o goes to 0 (pin floating) and reg_on_o goes to 0.
- R6: In standby and sleep, bus_dom_o stays 0 whatever the level of txd_i.
- R7: In sleep, a dominant bus seen for more than WAKE_TICKS*TICK_DIV consecutive synchronized cycles moves the block to standby, with inh_en_o and reg_on_o at 1.
- R8: A dominant bus seen for WAKE_TICKS*TICK_DIV cycles or fewer leaves the block in sleep. Any recessive sample restarts the filter. The filter runs only in sleep.
- R9: After a bus wake-up, rxd_o stays 0 in standby whatever the bus level.
- R10: Entering normal mode clears the wake flag, so rxd_o again follows the bus.
- R11: In standby, en_i low keeps the block in standby; it does not go to sleep.
- R12: A change on en_i, txd_i or bus_rx_i reaches the outputs only after the second rising clock edge following the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Mode enable pin, high selects normal mode |
| txd_i | input | 1 | Transmit data pin, low requests dominant |
| bus_rx_i | input | 1 | Receiver comparator output, 0 = dominant bus |
| bus_dom_o | output | 1 | 1 asks the output stage to pull the bus dominant |
| rxd_o | output | 1 | Receive data pin |
| inh_en_o | output | 1 | 1 drives the inhibit pin high, 0 leaves it high-impedance |
| reg_on_o | output | 1 | 1 while the regulator is meant to be on |

## Verification
The assertions take the three pin inputs as asynchronous levels. They reason only about the synchronized copies. They treat bus_rx_i as independent of bus_dom_o, as the receiver comparator would see a bus driven by other nodes. The stimulus changes inputs only on falling clock edges and holds each level for whole cycles, so the count of dominant cycles seen by the wake filter is known exactly. This allows probes just below, at and just above the filter time, plus a one-cycle recessive gap.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

    typedef enum logic [1:0] {
        LM_POWERUP = 2'd0,
        LM_STANDBY = 2'd1,
        LM_NORMAL  = 2'd2,
        LM_SLEEP   = 2'd3
    } lin_mode_e;

    typedef struct packed {
        lin_mode_e mode;
        logic      wake_flag;
    } lin_fsm_t;

endpackage

// File: rtl/lin_sync.sv
module lin_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  d_i,
    output logic [W-1:0]  q_o
);

    logic [STAGES-1:0][W-1:0] chain_d;
    logic [STAGES-1:0][W-1:0] chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/lin_wake_filter.sv
module lin_wake_filter #(
    parameter int TICK_DIV   = 125,
    parameter int WAKE_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed_i,
    input  logic dom_i,
    output logic wake_o
);

    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int CW = $clog2(WAKE_TICKS + 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
    localparam logic [CW-1:0] CNT_DONE = CW'(WAKE_TICKS);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t flt_d;
    flt_t flt_q;
    logic done;

    always_comb begin
        flt_d = flt_q;
        done  = (flt_q.cnt == CNT_DONE);
        if (!armed_i || !dom_i) begin
            flt_d = '0;
        end else if (!done) begin
            if (flt_q.pre == PRE_LAST) begin
                flt_d.pre = '0;
                flt_d.cnt = flt_q.cnt + 1'b1;
            end else begin
                flt_d.pre = flt_q.pre + 1'b1;
            end
        end
        wake_o = armed_i && dom_i && done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '0;
        end else begin
            flt_q <= flt_d;
        end
    end

endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
    import lin_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  logic      txd_i,
    input  logic      bus_i,
    input  logic      wake_i,
    output lin_mode_e mode_o,
    output logic      armed_o,
    output logic      bus_dom_o,
    output logic      rxd_o,
    output logic      inh_en_o,
    output logic      reg_on_o
);

    lin_fsm_t st_d;
    lin_fsm_t st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.mode)
            LM_POWERUP: st_d.mode = en_i ? LM_NORMAL : LM_STANDBY;
            LM_STANDBY: if (en_i) st_d.mode = LM_NORMAL;
            LM_NORMAL:  if (!en_i) st_d.mode = LM_SLEEP;
            LM_SLEEP: begin
                if (en_i) begin
                    st_d.mode = LM_NORMAL;
                end else if (wake_i) begin
                    st_d.mode      = LM_STANDBY;
                    st_d.wake_flag = 1'b1;
                end
            end
            default:    st_d.mode = LM_STANDBY;
        endcase
        if (st_d.mode == LM_NORMAL) begin
            st_d.wake_flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: LM_POWERUP, wake_flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mode_o    = st_q.mode;
        armed_o   = (st_q.mode == LM_SLEEP);
        bus_dom_o = (st_q.mode == LM_NORMAL) && !txd_i;
        rxd_o     = (st_q.mode == LM_NORMAL) ? bus_i : !st_q.wake_flag;
        inh_en_o  = (st_q.mode != LM_SLEEP);
        reg_on_o  = (st_q.mode != LM_SLEEP);
    end

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
    import lin_mode_pkg::*;
#(
    parameter int TICK_DIV    = 125,
    parameter int WAKE_TICKS  = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic txd_i,
    input  logic bus_rx_i,
    output logic bus_dom_o,
    output logic rxd_o,
    output logic inh_en_o,
    output logic reg_on_o
);

    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] PIN_IDLE = 3'b011; // {en, txd, bus}

    logic [NPIN-1:0] pins_s;
    logic            en_s;
    logic            txd_s;
    logic            bus_s;
    logic            wake;
    logic            armed;
    lin_mode_e       mode;

    lin_sync #(
        .W       (NPIN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({en_i, txd_i, bus_rx_i}),
        .q_o   (pins_s)
    );

    assign en_s  = pins_s[2];
    assign txd_s = pins_s[1];
    assign bus_s = pins_s[0];

    lin_wake_filter #(
        .TICK_DIV   (TICK_DIV),
        .WAKE_TICKS (WAKE_TICKS)
    ) i_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed_i (armed),
        .dom_i   (!bus_s),
        .wake_o  (wake)
    );

    lin_mode_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_s),
        .txd_i     (txd_s),
        .bus_i     (bus_s),
        .wake_i    (wake),
        .mode_o    (mode),
        .armed_o   (armed),
        .bus_dom_o (bus_dom_o),
        .rxd_o     (rxd_o),
        .inh_en_o  (inh_en_o),
        .reg_on_o  (reg_on_o)
    );

endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk
    import lin_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_s,
    input  logic      bus_s,
    input  logic      wake,
    input  lin_mode_e mode,
    input  logic      bus_dom_o,
    input  logic      rxd_o,
    input  logic      inh_en_o,
    input  logic      reg_on_o
);

    AST_EN_SELECTS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        en_s |=> (mode == LM_NORMAL)); // R2

    AST_SLEEP_FROM_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(reg_on_o) || $fell(inh_en_o)) |-> ($past(mode) == LM_NORMAL)); // R5

    AST_DOM_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dom_o |-> (mode == LM_NORMAL)); // R6

    AST_WAKE_TO_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !en_s) |=> (mode == LM_STANDBY && !rxd_o && inh_en_o)); // R7

    AST_WAKE_ONLY_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (mode == LM_SLEEP)); // R8

    AST_NORMAL_RELEASES_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_NORMAL && $past(mode) != LM_NORMAL && bus_s) |-> rxd_o); // R10

    AST_STANDBY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_STANDBY && !en_s) |=> (mode == LM_STANDBY)); // R11

endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_s      (en_s),
    .bus_s     (bus_s),
    .wake      (wake),
    .mode      (mode),
    .bus_dom_o (bus_dom_o),
    .rxd_o     (rxd_o),
    .inh_en_o  (inh_en_o),
    .reg_on_o  (reg_on_o)
);

// File: tb/test_lin_mode_ctrl.sv
module test_lin_mode_ctrl;

    localparam int TDIV  = 4;
    localparam int WTCK  = 5;
    localparam int NFILT = TDIV * WTCK;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 1'b0;
    logic txd_i = 1'b1;
    logic bus_rx_i = 1'b1;
    logic bus_dom_o, rxd_o, inh_en_o, reg_on_o;

    always #4 clk = ~clk;

    lin_mode_ctrl #(
        .TICK_DIV   (TDIV),
        .WAKE_TICKS (WTCK)
    ) i_lin_mode_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .txd_i     (txd_i),
        .bus_rx_i  (bus_rx_i),
        .bus_dom_o (bus_dom_o),
        .rxd_o     (rxd_o),
        .inh_en_o  (inh_en_o),
        .reg_on_o  (reg_on_o)
    );

    typedef struct {
        string      req;
        logic [3:0] val; // {rxd, dom, inh_en, reg_on}
    } exp_t;

    exp_t sb_q[$];
    event ev_push;
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    task automatic expect_out(input string req, input logic rxd, input logic dom,
                              input logic inh, input logic regon);
        exp_t e;
        e.req = req;
        e.val = {rxd, dom, inh, regon};
        sb_q.push_back(e);
        -> ev_push;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        exp_t e;
        logic [3:0] act;
        while (sb_q.size() > 0) begin
            e   = sb_q.pop_front();
            act = {rxd_o, bus_dom_o, inh_en_o, reg_on_o};
            n_run++;
            if (act !== e.val) begin
                n_fail++;
                $display("FAIL %s: {rxd,dom,inh,reg} got %b expected %b at %0t",
                         e.req, act, e.val, $time);
            end
        end
    endtask

    initial begin
        forever begin
            @(ev_push);
            drain();
        end
    end

    initial begin
        cyc(2);
        expect_out("R1", 1, 0, 1, 1);
        rst_n = 1'b1;
        cyc(5);
        expect_out("R1", 1, 0, 1, 1);

        // standby ignores txd and a low enable
        txd_i = 1'b0;
        cyc(4);
        expect_out("R6", 1, 0, 1, 1);
        cyc(8);
        expect_out("R11", 1, 0, 1, 1);

        // enable -> normal, txd low drives dominant
        en_i = 1'b1;
        cyc(4);
        expect_out("R2", 1, 1, 1, 1);
        expect_out("R3", 1, 1, 1, 1);

        // two-edge synchronizer latency
        txd_i = 1'b1;
        cyc(1);
        expect_out("R12", 1, 1, 1, 1);
        cyc(1);
        expect_out("R12", 1, 0, 1, 1);
        expect_out("R3", 1, 0, 1, 1);

        // receive data follows bus
        bus_rx_i = 1'b0;
        cyc(4);
        expect_out("R4", 0, 0, 1, 1);
        bus_rx_i = 1'b1;
        cyc(4);
        expect_out("R4", 1, 0, 1, 1);

        // sleep
        en_i = 1'b0;
        cyc(4);
        expect_out("R5", 1, 0, 0, 0);
        txd_i = 1'b0;
        cyc(4);
        expect_out("R6", 1, 0, 0, 0);

        // dominant exactly the filter time: no wake
        bus_rx_i = 1'b0;
        cyc(NFILT);
        bus_rx_i = 1'b1;
        cyc(4);
        expect_out("R8", 1, 0, 0, 0);

        // long dominance broken by a one-cycle recessive gap
        bus_rx_i = 1'b0;
        cyc(NFILT - 4);
        bus_rx_i = 1'b1;
        cyc(1);
        bus_rx_i = 1'b0;
        cyc(NFILT - 4);
        bus_rx_i = 1'b1;
        cyc(4);
        expect_out("R8", 1, 0, 0, 0);

        // one cycle beyond the filter time: wake
        bus_rx_i = 1'b0;
        cyc(NFILT + 1);
        bus_rx_i = 1'b1;
        cyc(4);
        expect_out("R7", 0, 0, 1, 1);
        expect_out("R9", 0, 0, 1, 1);
        bus_rx_i = 1'b0;
        cyc(4);
        bus_rx_i = 1'b1;
        cyc(4);
        expect_out("R9", 0, 0, 1, 1);
        cyc(6);
        expect_out("R11", 0, 0, 1, 1);

        // normal clears the flag
        en_i = 1'b1;
        cyc(4);
        expect_out("R10", 1, 1, 1, 1);
        bus_rx_i = 1'b0;
        cyc(4);
        expect_out("R10", 0, 1, 1, 1);
        bus_rx_i = 1'b1;
        cyc(4);
        expect_out("R4", 1, 1, 1, 1);

        // sleep then straight to normal without wake
        en_i = 1'b0;
        cyc(4);
        expect_out("R5", 1, 0, 0, 0);
        en_i = 1'b1;
        cyc(4);
        expect_out("R2", 1, 1, 1, 1);

        cyc(2);
        drain();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule